// File: doc/BRIEF.md
# Indirect Interrupt Controller Register File

This block holds the programmable state of an I/O interrupt controller. Host software sees only two 32-bit locations: an index register and a data window. To reach anything else, software writes an index into the index register and then reads or writes the window. Behind the window sit four kinds of register:

- a writable controller ID, which names the controller on its message bus;
- a read-only version word;
- a read-only arbitration ID;
- a redirection table with one entry per interrupt input, each entry split into two 32-bit halves.

Writing the controller ID also copies the same value into the arbitration ID. The arbitration logic uses that copy.

Every redirection entry carries an interrupt vector, a trigger mode (edge or level), a destination, a destination selection mode (static or dynamic) and a mask bit. The block exports all of these fields, together with the arbitration ID, as flat vectors to the dispatch logic. Reads through either host location are combinational. Writes land on the clock edge that samples the write strobe.

Top module: `ioint_regfile`

## Requirements
- R1: Host location 0 (`bus_addr`=0) is the index register. A write stores `bus_wdata[7:0]`, and a read returns the stored index zero-extended to 32 bits. Host location 1 is the data window.
- R2: A window read returns, combinationally, the register named by the current index. A window write updates that register on the clock edge that samples `bus_wr`, so `bus_rdata` shows the old value until that edge.
- R3: Index 0x00 is the controller ID. Bits [3:0] are writable, and all other bits read as zero.
- R4: A window write to index 0x00 also loads `bus_wdata[3:0]` into the arbitration ID. Index 0x02 reads the arbitration ID in bits [3:0]. Writes to index 0x02 are ignored. `arb_id_o` shows the arbitration ID and changes only through ID writes or reset.
- R5: Index 0x01 is read-only. It returns the version code (default 0x11) in bits [7:0] and the entry count minus one in bits [23:16]; with the defaults the word is 0x000F0011. Writes to it are ignored.
- R6: Any unused index reads as zero. A write to an unused index changes no register. Unused means 0x03 to 0x0F, and from 0x10 + 2×entries up to 0xFF.
- R7: Index 0x10+2n is the low half of entry n. Its fields are:
  - vector in bits [7:0];
  - dynamic destination selection in bit 8;
  - level trigger in bit 9;
  - mask in bit 16.

  All other bits read as zero and ignore writes.
- R8: Index 0x11+2n is the high half of entry n. The destination is in bits [7:0], and all other bits read as zero.
- R9: After reset the index, the ID and the arbitration ID are zero. Every entry's low half reads 0x00010000 (masked) and every high half reads zero.
- R10: Entry n drives `ent_vector_o[8n+:8]`, `ent_dest_o[8n+:8]`, `ent_dynamic_o[n]`, `ent_level_o[n]` and `ent_mask_o[n]`. A write to one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the host location given by bus_addr |
| bus_addr | input | 1 | 0 selects the index register, 1 selects the data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed location |
| arb_id_o | output | 4 | Arbitration ID |
| ent_vector_o | output | 128 | Vector of each entry, 8 bits per entry |
| ent_dest_o | output | 128 | Destination of each entry, 8 bits per entry |
| ent_level_o | output | 16 | Level trigger flag of each entry |
| ent_dynamic_o | output | 16 | Dynamic destination selection flag of each entry |
| ent_mask_o | output | 16 | Mask flag of each entry |

## Verification
The bench builds the block with its defaults: 16 entries, a 4-bit ID and version code 0x11. With these values the last entry's halves sit at indices 0x2E and 0x2F, and 0x30 is the first unused index above the table. Both edges of the table and both unused gaps can therefore be reached with 8-bit index writes. The fixed version word 0x000F0011 gives an exact value to compare against both before and after a write attempt on index 0x01.

// File: rtl/ioint_regs_pkg.sv
package ioint_regs_pkg;

  localparam int IDX_W        = 8;
  localparam int VEC_W        = 8;
  localparam int IDX_ID       = 8'h00;
  localparam int IDX_VER      = 8'h01;
  localparam int IDX_ARB      = 8'h02;
  localparam int IDX_ENT_BASE = 8'h10;

  localparam int BIT_DYN  = 8;
  localparam int BIT_LVL  = 9;
  localparam int BIT_MASK = 16;

  typedef enum logic [2:0] {
    K_NONE,
    K_ID,
    K_VER,
    K_ARB,
    K_ENT_LO,
    K_ENT_HI
  } kind_e;

  function automatic kind_e idx_kind(input logic [IDX_W-1:0] idx, input int n_ent);
    int i;
    i = int'(idx);
    if (i == IDX_ID)  return K_ID;
    if (i == IDX_VER) return K_VER;
    if (i == IDX_ARB) return K_ARB;
    if (i >= IDX_ENT_BASE && i < IDX_ENT_BASE + 2 * n_ent)
      return idx[0] ? K_ENT_HI : K_ENT_LO;
    return K_NONE;
  endfunction

  function automatic logic [IDX_W-1:0] entry_of(input logic [IDX_W-1:0] idx);
    return (idx - IDX_W'(IDX_ENT_BASE)) >> 1;
  endfunction

  function automatic logic [31:0] version_word(input logic [7:0] ver, input int n_ent);
    return {8'h00, 8'(n_ent - 1), 8'h00, ver};
  endfunction

  function automatic logic [31:0] lo_word(input logic [VEC_W-1:0] vec,
                                          input logic dyn, input logic lvl,
                                          input logic msk);
    logic [31:0] w;
    w = 32'(vec);
    w[BIT_DYN]  = dyn;
    w[BIT_LVL]  = lvl;
    w[BIT_MASK] = msk;
    return w;
  endfunction

endpackage

// File: rtl/ioint_win_decode.sv
module ioint_win_decode
  import ioint_regs_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int ENT_W = $clog2(N_ENT)
) (
  input  logic [IDX_W-1:0] sel_i,
  input  logic             win_wr_i,
  output kind_e            kind_o,
  output logic [ENT_W-1:0] ent_o,
  output logic             id_we_o,
  output logic [N_ENT-1:0] lo_we_o,
  output logic [N_ENT-1:0] hi_we_o
);

  always_comb begin
    kind_o  = idx_kind(sel_i, N_ENT);
    ent_o   = ENT_W'(entry_of(sel_i));
    id_we_o = win_wr_i && (kind_o == K_ID);
    lo_we_o = '0;
    hi_we_o = '0;
    if (win_wr_i && kind_o == K_ENT_LO) lo_we_o[ent_o] = 1'b1;
    if (win_wr_i && kind_o == K_ENT_HI) hi_we_o[ent_o] = 1'b1;
  end

endmodule

// File: rtl/ioint_id_block.sv
module ioint_id_block #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_we_i,
  input  logic [ID_W-1:0] id_wd_i,
  output logic [ID_W-1:0] id_o,
  output logic [ID_W-1:0] arb_o
);

  logic [ID_W-1:0] id_q;
  logic [ID_W-1:0] arb_q;

  // The arbitration copy is a register of its own, loaded only by ID writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      arb_q <= '0;
    end else if (id_we_i) begin
      id_q  <= id_wd_i;
      arb_q <= id_wd_i;
    end
  end

  assign id_o  = id_q;
  assign arb_o = arb_q;

endmodule

// File: rtl/ioint_redir_entry.sv
module ioint_redir_entry
  import ioint_regs_pkg::*;
#(
  parameter int DEST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [VEC_W-1:0]  wd_vec_i,
  input  logic              wd_dyn_i,
  input  logic              wd_lvl_i,
  input  logic              wd_mask_i,
  input  logic [DEST_W-1:0] wd_dest_i,
  output logic [31:0]       lo_word_o,
  output logic [31:0]       hi_word_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [DEST_W-1:0] dest_o,
  output logic              dyn_o,
  output logic              lvl_o,
  output logic              mask_o
);

  logic [VEC_W-1:0]  vec_q;
  logic [DEST_W-1:0] dest_q;
  logic              dyn_q, lvl_q, mask_q;

  // Only the defined fields are stored; reserved bits have no flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      dyn_q  <= 1'b0;
      lvl_q  <= 1'b0;
      mask_q <= 1'b1;
    end else if (we_lo_i) begin
      vec_q  <= wd_vec_i;
      dyn_q  <= wd_dyn_i;
      lvl_q  <= wd_lvl_i;
      mask_q <= wd_mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dest_q <= '0;
    else if (we_hi_i) dest_q <= wd_dest_i;
  end

  assign lo_word_o = lo_word(vec_q, dyn_q, lvl_q, mask_q);
  assign hi_word_o = 32'(dest_q);
  assign vec_o     = vec_q;
  assign dest_o    = dest_q;
  assign dyn_o     = dyn_q;
  assign lvl_o     = lvl_q;
  assign mask_o    = mask_q;

endmodule

// File: rtl/ioint_rd_mux.sv
module ioint_rd_mux
  import ioint_regs_pkg::*;
#(
  parameter int         N_ENT   = 16,
  parameter int         ID_W    = 4,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int         ENT_W   = $clog2(N_ENT)
) (
  input  kind_e            kind_i,
  input  logic [ENT_W-1:0] ent_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [ID_W-1:0]  arb_i,
  input  logic [31:0]      lo_i [N_ENT],
  input  logic [31:0]      hi_i [N_ENT],
  output logic [31:0]      rdata_o
);

  always_comb begin
    unique case (kind_i)
      K_ID:     rdata_o = 32'(id_i);
      K_VER:    rdata_o = version_word(VERSION, N_ENT);
      K_ARB:    rdata_o = 32'(arb_i);
      K_ENT_LO: rdata_o = lo_i[ent_i];
      K_ENT_HI: rdata_o = hi_i[ent_i];
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/ioint_regfile.sv
module ioint_regfile
  import ioint_regs_pkg::*;
#(
  parameter int         N_ENT   = 16,
  parameter int         ID_W    = 4,
  parameter int         DEST_W  = 8,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic [ID_W-1:0]         arb_id_o,
  output logic [N_ENT*VEC_W-1:0]  ent_vector_o,
  output logic [N_ENT*DEST_W-1:0] ent_dest_o,
  output logic [N_ENT-1:0]        ent_level_o,
  output logic [N_ENT-1:0]        ent_dynamic_o,
  output logic [N_ENT-1:0]        ent_mask_o
);

  localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  // Named internal events, visible to the bound checker.
  logic [IDX_W-1:0] sel_q;
  logic             sel_wr;
  logic             win_wr;
  kind_e            kind;
  logic [ENT_W-1:0] ent_sel;
  logic             id_we;
  logic [N_ENT-1:0] lo_we, hi_we;
  logic [ID_W-1:0]  id_val;
  logic [31:0]      win_rdata;
  logic [31:0]      lo_words [N_ENT];
  logic [31:0]      hi_words [N_ENT];
  logic             unused_wbits;

  assign sel_wr       = bus_wr && !bus_addr;
  assign win_wr       = bus_wr && bus_addr;
  assign unused_wbits = ^{bus_wdata[31:BIT_MASK+1], bus_wdata[BIT_MASK-1:BIT_LVL+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= bus_wdata[IDX_W-1:0];
  end

  ioint_win_decode #(.N_ENT(N_ENT), .ENT_W(ENT_W)) u_dec (
    .sel_i    (sel_q),
    .win_wr_i (win_wr),
    .kind_o   (kind),
    .ent_o    (ent_sel),
    .id_we_o  (id_we),
    .lo_we_o  (lo_we),
    .hi_we_o  (hi_we)
  );

  ioint_id_block #(.ID_W(ID_W)) u_id (
    .clk     (clk),
    .rst_n   (rst_n),
    .id_we_i (id_we),
    .id_wd_i (bus_wdata[ID_W-1:0]),
    .id_o    (id_val),
    .arb_o   (arb_id_o)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    ioint_redir_entry #(.DEST_W(DEST_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_lo_i   (lo_we[g]),
      .we_hi_i   (hi_we[g]),
      .wd_vec_i  (bus_wdata[VEC_W-1:0]),
      .wd_dyn_i  (bus_wdata[BIT_DYN]),
      .wd_lvl_i  (bus_wdata[BIT_LVL]),
      .wd_mask_i (bus_wdata[BIT_MASK]),
      .wd_dest_i (bus_wdata[DEST_W-1:0]),
      .lo_word_o (lo_words[g]),
      .hi_word_o (hi_words[g]),
      .vec_o     (ent_vector_o[g*VEC_W +: VEC_W]),
      .dest_o    (ent_dest_o[g*DEST_W +: DEST_W]),
      .dyn_o     (ent_dynamic_o[g]),
      .lvl_o     (ent_level_o[g]),
      .mask_o    (ent_mask_o[g])
    );
  end

  ioint_rd_mux #(.N_ENT(N_ENT), .ID_W(ID_W), .VERSION(VERSION), .ENT_W(ENT_W)) u_mux (
    .kind_i  (kind),
    .ent_i   (ent_sel),
    .id_i    (id_val),
    .arb_i   (arb_id_o),
    .lo_i    (lo_words),
    .hi_i    (hi_words),
    .rdata_o (win_rdata)
  );

  assign bus_rdata = bus_addr ? win_rdata : 32'(sel_q);

endmodule

// File: rtl/ioint_regfile_chk.sv
module ioint_regfile_chk
  import ioint_regs_pkg::*;
#(
  parameter int         N_ENT   = 16,
  parameter int         ID_W    = 4,
  parameter logic [7:0] VERSION = 8'h11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [ID_W-1:0]        arb_id_o,
  input logic [N_ENT-1:0]       ent_mask_o,
  input logic [IDX_W-1:0]       sel_q,
  input logic                   sel_wr,
  input logic                   win_wr,
  input logic                   id_we,
  input kind_e                  kind
);

  localparam logic [31:0] VER_EXP = {8'h00, 8'(N_ENT - 1), 8'h00, VERSION};

  // R1: an index write is visible in the index register after the edge
  a_r1_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_q == $past(bus_wdata[IDX_W-1:0]));

  // R4: an ID write loads the arbitration copy
  a_r4_arb_load: assert property (@(posedge clk) disable iff (!rst_n)
    id_we |=> arb_id_o == $past(bus_wdata[ID_W-1:0]));

  // R4: without an ID write the arbitration copy holds
  a_r4_arb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !id_we |=> $stable(arb_id_o));

  // R5: the version word is fixed
  a_r5_version: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr && kind == K_VER) |-> bus_rdata == VER_EXP);

  // R6: unused indices read zero
  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr && kind == K_NONE) |-> bus_rdata == 32'h0);

  // R10: masks change only through a window write
  a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> $stable(ent_mask_o));

endmodule

bind ioint_regfile ioint_regfile_chk #(.N_ENT(N_ENT), .ID_W(ID_W), .VERSION(VERSION)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .arb_id_o   (arb_id_o),
  .ent_mask_o (ent_mask_o),
  .sel_q      (sel_q),
  .sel_wr     (sel_wr),
  .win_wr     (win_wr),
  .id_we      (id_we),
  .kind       (kind)
);

// File: tb/ioint_regfile_bench.sv
module ioint_regfile_bench;

  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_addr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [3:0]    arb_id_o;
  logic [N*8-1:0] ent_vector_o, ent_dest_o;
  logic [N-1:0]  ent_level_o, ent_dynamic_o, ent_mask_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ioint_regfile u_ioint_regfile (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arb_id_o(arb_id_o),
    .ent_vector_o(ent_vector_o), .ent_dest_o(ent_dest_o),
    .ent_level_o(ent_level_o), .ent_dynamic_o(ent_dynamic_o), .ent_mask_o(ent_mask_o)
  );

  typedef struct packed {
    logic        wr;
    logic        adr;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  // R1 index/window, R3 ID, R4 arb copy, R5 version, R6 unused,
  // R7 low half, R8 high half, R9 reset values, R10 entry isolation
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h0,        32'h0,        8'd9},
    '{1'b0, 1'b1, 32'h0,        32'h0,        8'd9},
    '{1'b1, 1'b0, 32'h1,        32'h0,        8'd1},
    '{1'b0, 1'b0, 32'h0,        32'h1,        8'd1},
    '{1'b0, 1'b1, 32'h0,        32'h000F0011, 8'd5},
    '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h0,        8'd5},
    '{1'b0, 1'b1, 32'h0,        32'h000F0011, 8'd5},
    '{1'b1, 1'b0, 32'h0,        32'h0,        8'd3},
    '{1'b1, 1'b1, 32'hABCDEF5A, 32'h0,        8'd3},
    '{1'b0, 1'b1, 32'h0,        32'hA,        8'd3},
    '{1'b1, 1'b0, 32'h2,        32'h0,        8'd4},
    '{1'b0, 1'b1, 32'h0,        32'hA,        8'd4},
    '{1'b1, 1'b1, 32'h3,        32'h0,        8'd4},
    '{1'b0, 1'b1, 32'h0,        32'hA,        8'd4},
    '{1'b1, 1'b0, 32'h10,       32'h0,        8'd7},
    '{1'b0, 1'b1, 32'h0,        32'h00010000, 8'd9},
    '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h0,        8'd7},
    '{1'b0, 1'b1, 32'h0,        32'h000103FF, 8'd7},
    '{1'b1, 1'b1, 32'h00000231, 32'h0,        8'd7},
    '{1'b0, 1'b1, 32'h0,        32'h00000231, 8'd7},
    '{1'b1, 1'b0, 32'h11,       32'h0,        8'd8},
    '{1'b0, 1'b1, 32'h0,        32'h0,        8'd9},
    '{1'b1, 1'b1, 32'hFFFFFF77, 32'h0,        8'd8},
    '{1'b0, 1'b1, 32'h0,        32'h77,       8'd8},
    '{1'b1, 1'b0, 32'h2F,       32'h0,        8'd8},
    '{1'b1, 1'b1, 32'h12345699, 32'h0,        8'd8},
    '{1'b0, 1'b1, 32'h0,        32'h99,       8'd8},
    '{1'b1, 1'b0, 32'h2E,       32'h0,        8'd10},
    '{1'b0, 1'b1, 32'h0,        32'h00010000, 8'd10},
    '{1'b1, 1'b0, 32'h03,       32'h0,        8'd6},
    '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h0,        8'd6},
    '{1'b0, 1'b1, 32'h0,        32'h0,        8'd6},
    '{1'b1, 1'b0, 32'h30,       32'h0,        8'd6},
    '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h0,        8'd6},
    '{1'b0, 1'b1, 32'h0,        32'h0,        8'd6},
    '{1'b1, 1'b0, 32'h0,        32'h0,        8'd6},
    '{1'b0, 1'b1, 32'h0,        32'hA,        8'd6}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].adr, VECS[i].dat);
      else begin
        bus_read(VECS[i].adr, rd);
        check(rd, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
      end
    end

    // R10 and R4 at the export ports
    #1;
    check(32'(ent_vector_o[7:0]), 32'h31, "R10 vector entry0");
    check(32'(ent_level_o[0]), 32'h1, "R10 level entry0");
    check(32'(ent_dynamic_o[0]), 32'h0, "R10 dynamic entry0");
    check(32'(ent_mask_o[0]), 32'h0, "R10 mask entry0");
    check(32'(ent_dest_o[7:0]), 32'h77, "R10 dest entry0");
    check(32'(ent_dest_o[127:120]), 32'h99, "R10 dest entry15");
    check(32'(ent_mask_o[15:1]), 32'h7FFF, "R10 other masks set");
    check(32'(arb_id_o), 32'hA, "R4 arb port");

    // R2: the old value shows until the edge that samples the write
    bus_write(1'b0, 32'h12);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h00000105;
    #1 check(bus_rdata, 32'h00010000, "R2 before edge");
    @(negedge clk);
    bus_wr = 1'b0;
    #1 check(bus_rdata, 32'h00000105, "R2 after edge");

    // R10: write every entry, then check each export
    for (int n = 0; n < N; n++) begin
      bus_write(1'b0, 32'h10 + 32'(2 * n));
      bus_write(1'b1, {22'h0, n[0], 1'b0, 8'(8'h40 + n)});
    end
    #1;
    for (int n = 0; n < N; n++) begin
      check(32'(ent_vector_o[n*8 +: 8]), 32'h40 + 32'(n), $sformatf("R10 vector %0d", n));
      check(32'(ent_level_o[n]), 32'(n % 2), $sformatf("R10 level %0d", n));
    end
    check(32'(ent_mask_o), 32'h0, "R10 all unmasked");

    // R4: a new ID updates the arbitration copy
    bus_write(1'b0, 32'h0);
    bus_write(1'b1, 32'h5);
    #1 check(32'(arb_id_o), 32'h5, "R4 arb reload");

    // R9: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    bus_addr = 1'b0;
    #1;
    check(32'(ent_mask_o), 32'hFFFF, "R9 masks after reset");
    check(32'(arb_id_o), 32'h0, "R9 arb after reset");
    check(bus_rdata, 32'h0, "R9 index after reset");
    @(negedge clk);
    rst_n = 1'b1;
    bus_write(1'b0, 32'h13);
    bus_read(1'b1, rd);
    check(rd, 32'h0, "R9 high half after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule